// File: doc/BRIEF.md
# ADC Channel Scan Sequencer with Result Readback

This block is the digital control core of a multichannel serial ADC that sits on a two-wire bus. Bytes written by the bus master arrive already decoded from the bit level. Bit 7 of each byte says whether it goes to the setup register or to the configuration register. A read-addressing strobe starts a scan, and the scan's channel list comes from a two-bit scan mode and a selected channel. Each conversion is requested from an external converter through a start/done/data handshake. The converter is modelled only as that handshake.

There are two modes. In internal-clock mode, every result of the scan is written in turn into a small result RAM, and the block holds the bus clock low until the last conversion has finished. The master then reads the results one byte per request, oldest first. The read pointer wraps after the last stored result. In external-clock mode there is no stretching. Each result is streamed to the read interface as soon as it is converted, and the channel list repeats until the master answers with a not-acknowledge.

Top module: `adc_scan_ctrl`

## Requirements
- R1: A written byte with bit 7 = 1 loads setup: bit 6 = reference sharing (channel NCH-1 is used as reference), bit 3 = external-clock mode. A byte with bit 7 = 0 loads configuration: bits 6:5 = scan mode, bits 3:1 = selected channel at the default NCH of 8. After reset the state is: scan mode 11, channel 0, internal clock, no reference sharing.
- R2: Scan mode 00 converts channels 0 up to the selected channel, in ascending order. Mode 01 converts the selected channel DEPTH times. Mode 10 converts NCH/2 up to the selected channel, or only the selected channel if it is below NCH/2. Mode 11 converts the selected channel once.
- R3: With reference sharing on, channel NCH-1 is skipped in modes 00 and 10. It is still converted in modes 01 and 11.
- R4: Conversions run back to back. There is one conv_start pulse per conversion, and the next pulse comes only after conv_done. The number of conversions equals the length of the list.
- R5: In internal-clock mode, hold_scl is high from the cycle after the accepted address strobe. It drops in the cycle after the edge that captures the final conv_done.
- R6: Each accepted rd_req gives rd_valid with the next stored result one cycle later, in conversion order. After the last stored result the next read returns the first. A one-result scan returns the same byte on every read.
- R7: rd_req gives no rd_valid while hold_scl is high, or before any scan has stored results.
- R8: An address strobe during a scan is ignored. Configuration or setup written during a scan applies only to the next scan.
- R9: A new internal scan discards the previous results, and reading restarts at its first result.
- R10: In external-clock mode hold_scl stays low. Each result appears on rd_data with rd_valid the cycle after conv_done, and the list repeats. rd_nack drops the conversion in flight, stops further conversions and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Decoded write byte is valid |
| wr_byte | input | 8 | Setup or configuration byte |
| addr_rd | input | 1 | Read-addressing strobe; starts a scan |
| rd_req | input | 1 | Request for the next result byte |
| rd_nack | input | 1 | Master not-acknowledge; ends an external-clock run |
| rd_valid | output | 1 | rd_data carries a result this cycle |
| rd_data | output | 8 | Result byte |
| hold_scl | output | 1 | Clock-stretch request |
| conv_start | output | 1 | One-cycle conversion request |
| conv_ch | output | $clog2(NCH) | Channel to convert |
| conv_done | input | 1 | Converter finished, conv_data valid |
| conv_data | input | 8 | Converted value |

## Verification
The assertions take the converter to be well behaved. It answers each conv_start with exactly one single-cycle conv_done, and never raises conv_done while no conversion is pending. They also take rd_nack to be sent only during an external-clock run. The bench's converter model answers only after it has seen conv_start, with a fixed latency, and the master model pulses rd_nack only while a streaming run is converting. Reads and strobes are issued while the block is busy only where the test is meant to show that they are ignored.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    SCAN_UPTO   = 2'b00,
    SCAN_REPEAT = 2'b01,
    SCAN_UPPER  = 2'b10,
    SCAN_SINGLE = 2'b11
  } scan_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'b00,
    SQ_ISSUE = 2'b01,
    SQ_WAIT  = 2'b10
  } seq_state_e;

  // first channel converted for a mode and selection
  function automatic int first_chan(scan_mode_e mode, int sel, int nch);
    if (mode == SCAN_UPTO) return 0;
    if (mode == SCAN_UPPER) return (sel >= nch / 2) ? nch / 2 : sel;
    return sel;
  endfunction

  // ascending step that hops over the reference-shared channel
  function automatic int step_chan(int cur, bit refsh, int nch);
    int n;
    n = cur + 1;
    if (refsh && n == nch - 1) n = n + 1;
    return n;
  endfunction

  // whether the conversion at (cur, cnt) closes the channel list
  function automatic bit list_ends_at(scan_mode_e mode, int cur, int sel, int cnt,
                                      bit refsh, int nch, int depth);
    case (mode)
      SCAN_REPEAT: return cnt == depth - 1;
      SCAN_SINGLE: return 1'b1;
      default:     return step_chan(cur, refsh, nch) > sel;
    endcase
  endfunction

  // read pointer advance with wrap over the stored count
  function automatic int wrap_inc(int ptr, int len);
    return (ptr + 1 >= len) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
  import adc_scan_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [7:0]      wr_byte,
  output scan_mode_e      cfg_mode,
  output logic [CH_W-1:0] cfg_sel,
  output logic            cfg_refsh,
  output logic            cfg_ext
);
  localparam int KIND_BIT  = 7;
  localparam int REFSH_BIT = 6;
  localparam int EXT_BIT   = 3;
  localparam int MODE_LSB  = 5;
  localparam int SEL_LSB   = 1;

  logic setup_hit, config_hit;
  assign setup_hit  = wr_valid &&  wr_byte[KIND_BIT];
  assign config_hit = wr_valid && !wr_byte[KIND_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode  <= SCAN_SINGLE;
      cfg_sel   <= '0;
      cfg_refsh <= 1'b0;
      cfg_ext   <= 1'b0;
    end else begin
      if (setup_hit) begin
        cfg_refsh <= wr_byte[REFSH_BIT];
        cfg_ext   <= wr_byte[EXT_BIT];
      end
      if (config_hit) begin
        cfg_mode <= scan_mode_e'(wr_byte[MODE_LSB +: 2]);
        cfg_sel  <= wr_byte[SEL_LSB +: CH_W];
      end
    end
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = wr_byte[0] ^ wr_byte[4];

  // R1: a setup byte never disturbs the configuration fields
  p_setup_keeps_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    setup_hit |=> $stable({cfg_mode, cfg_sel}));
  // R1: a configuration byte never disturbs the setup fields
  p_cfg_keeps_setup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    config_hit |=> $stable({cfg_refsh, cfg_ext}));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int CH_W  = $clog2(NCH),
  localparam int PW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_strobe,
  input  logic             nack,
  input  scan_mode_e       cfg_mode,
  input  logic [CH_W-1:0]  cfg_sel,
  input  logic             cfg_refsh,
  input  logic             cfg_ext,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_ch,
  input  logic             conv_done,
  input  logic [DW-1:0]    conv_data,
  output logic             res_we,
  output logic [PW-1:0]    res_idx,
  output logic [DW-1:0]    res_data,
  output logic             int_begin,
  output logic             scan_fin,
  output logic [CNT_W-1:0] fin_len,
  output logic             busy,
  output logic             hold,
  output logic             out_valid,
  output logic [DW-1:0]    out_data
);
  localparam int SHARED = NCH - 1;

  seq_state_e       state;
  scan_mode_e       run_mode;
  logic [CH_W-1:0]  run_sel;
  logic             run_rs;
  logic             run_ext;
  logic [CH_W-1:0]  cur_ch;
  logic [CNT_W-1:0] cnt;
  logic             stop_q;

  // named internal events
  logic             take_scan;
  logic             done_hit;
  logic             last_conv;
  logic             drop_conv;
  logic [CH_W-1:0]  nxt_ch;
  logic [CH_W-1:0]  head_ch;

  assign take_scan = (state == SQ_IDLE) && addr_strobe;
  assign done_hit  = (state == SQ_WAIT) && conv_done;
  assign drop_conv = done_hit && run_ext && (stop_q || nack);
  assign last_conv = list_ends_at(run_mode, int'(cur_ch), int'(run_sel), int'(cnt),
                                  run_rs, NCH, DEPTH);
  assign head_ch   = CH_W'(first_chan(run_mode, int'(run_sel), NCH));
  assign nxt_ch    = (run_mode == SCAN_UPTO || run_mode == SCAN_UPPER)
                   ? CH_W'(step_chan(int'(cur_ch), run_rs, NCH)) : cur_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      run_mode  <= SCAN_SINGLE;
      run_sel   <= '0;
      run_rs    <= 1'b0;
      run_ext   <= 1'b0;
      cur_ch    <= '0;
      cnt       <= '0;
      stop_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (run_ext && state != SQ_IDLE && nack) stop_q <= 1'b1;
      case (state)
        SQ_IDLE: begin
          if (addr_strobe) begin
            run_mode <= cfg_mode;
            run_sel  <= cfg_sel;
            run_rs   <= cfg_refsh;
            run_ext  <= cfg_ext;
            cur_ch   <= CH_W'(first_chan(cfg_mode, int'(cfg_sel), NCH));
            cnt      <= '0;
            stop_q   <= 1'b0;
            state    <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: begin
          state <= stop_q ? SQ_IDLE : SQ_WAIT;
        end
        SQ_WAIT: begin
          if (conv_done) begin
            if (drop_conv) begin
              state <= SQ_IDLE;
            end else if (run_ext) begin
              out_valid <= 1'b1;
              out_data  <= conv_data;
              state     <= SQ_ISSUE;
              if (last_conv) begin
                cur_ch <= head_ch;
                cnt    <= '0;
              end else begin
                cur_ch <= nxt_ch;
                cnt    <= cnt + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
              if (last_conv) begin
                state <= SQ_IDLE;
              end else begin
                cur_ch <= nxt_ch;
                state  <= SQ_ISSUE;
              end
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign conv_start = (state == SQ_ISSUE) && !stop_q;
  assign conv_ch    = cur_ch;
  assign res_we     = done_hit && !run_ext;
  assign res_idx    = cnt[PW-1:0];
  assign res_data   = conv_data;
  assign int_begin  = take_scan && !cfg_ext;
  assign scan_fin   = res_we && last_conv;
  assign fin_len    = cnt + 1'b1;
  assign busy       = (state != SQ_IDLE);
  assign hold       = busy && !run_ext;

  // R4: start is a single-cycle pulse
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R4: a request always leads into the wait for done
  p_start_then_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (state == SQ_WAIT));
  // R4: the write slot stays inside the RAM
  p_slot_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_WAIT) |-> (cnt < CNT_W'(DEPTH)));
  // R2: only existing channels are requested
  p_chan_exists_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (int'(conv_ch) < NCH));
  // R3: the shared channel never appears in an ascending scan when it is the reference
  p_skip_shared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && run_rs && (run_mode == SCAN_UPTO || run_mode == SCAN_UPPER))
      |-> (int'(conv_ch) != SHARED));
  // R8: the selection cannot change while a scan runs
  p_run_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({run_mode, run_sel, run_rs, run_ext}));
  // R10: an external-clock run never stretches
  p_ext_no_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_ext) |-> !hold);

endmodule

// File: rtl/adc_result_store.sv
module adc_result_store
  import adc_scan_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             we,
  input  logic [PW-1:0]    wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             commit,
  input  logic [CNT_W-1:0] commit_len,
  input  logic             rd_block,
  input  logic             rd_req,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0]    mem [DEPTH];
  logic [CNT_W-1:0] len;
  logic [PW-1:0]    rptr;
  logic             rd_take;

  assign rd_take = rd_req && !rd_block && !clear && (len != '0);

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len      <= '0;
      rptr     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (clear) begin
        len  <= '0;
        rptr <= '0;
      end else begin
        if (commit) len <= commit_len;
        if (rd_take) begin
          rd_valid <= 1'b1;
          rd_data  <= mem[rptr];
          rptr     <= PW'(wrap_inc(int'(rptr), int'(len)));
        end
      end
    end
  end

  // R6: the read pointer stays within the stored results
  p_ptr_in_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (len != '0) |-> ({1'b0, rptr} < (PW + 1)'(len)));
  // R7: nothing is returned while reads are blocked
  p_blocked_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_block || len == '0) |=> !rd_valid);

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 8,
  localparam int DW    = 8,
  localparam int PW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  input  logic [7:0]              wr_byte,
  input  logic                    addr_rd,
  input  logic                    rd_req,
  input  logic                    rd_nack,
  output logic                    rd_valid,
  output logic [7:0]              rd_data,
  output logic                    hold_scl,
  output logic                    conv_start,
  output logic [$clog2(NCH)-1:0]  conv_ch,
  input  logic                    conv_done,
  input  logic [7:0]              conv_data
);
  localparam int CH_W = $clog2(NCH);

  scan_mode_e       cfg_mode;
  logic [CH_W-1:0]  cfg_sel;
  logic             cfg_refsh, cfg_ext;
  logic             res_we, int_begin, scan_fin, busy;
  logic [PW-1:0]    res_idx;
  logic [DW-1:0]    res_data;
  logic [CNT_W-1:0] fin_len;
  logic             stream_v, store_v;
  logic [DW-1:0]    stream_d, store_d;

  adc_cfg_regs #(.NCH(NCH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .cfg_mode(cfg_mode), .cfg_sel(cfg_sel), .cfg_refsh(cfg_refsh), .cfg_ext(cfg_ext)
  );

  adc_scan_seq #(.NCH(NCH), .DEPTH(DEPTH), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_rd), .nack(rd_nack),
    .cfg_mode(cfg_mode), .cfg_sel(cfg_sel), .cfg_refsh(cfg_refsh), .cfg_ext(cfg_ext),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data),
    .res_we(res_we), .res_idx(res_idx), .res_data(res_data),
    .int_begin(int_begin), .scan_fin(scan_fin), .fin_len(fin_len),
    .busy(busy), .hold(hold_scl), .out_valid(stream_v), .out_data(stream_d)
  );

  adc_result_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(int_begin),
    .we(res_we), .wr_idx(res_idx), .wr_data(res_data),
    .commit(scan_fin), .commit_len(fin_len),
    .rd_block(busy || addr_rd), .rd_req(rd_req),
    .rd_valid(store_v), .rd_data(store_d)
  );

  assign rd_valid = stream_v || store_v;
  assign rd_data  = stream_v ? stream_d : store_d;

  // R5: the stretch is released only right after the final result arrived
  p_hold_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_scl) |-> $past(conv_done));
  // R7: no byte is returned during a stretch
  p_no_read_in_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_scl |=> !rd_valid);
  // R10: the streamed and stored paths never answer together
  p_one_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(stream_v && store_v));

endmodule

// File: tb/sim_adc_scan_ctrl.sv
module sim_adc_scan_ctrl;
  localparam int NCH = 8;
  localparam int DEPTH = 8;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, wr_valid, addr_rd, rd_req, rd_nack, conv_done;
  logic [7:0] wr_byte, conv_data, rd_data;
  logic rd_valid, hold_scl, conv_start;
  logic [2:0] conv_ch;

  adc_scan_ctrl #(.NCH(NCH), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .addr_rd(addr_rd), .rd_req(rd_req), .rd_nack(rd_nack),
    .rd_valid(rd_valid), .rd_data(rd_data), .hold_scl(hold_scl),
    .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data)
  );

  int ncomp = 0;
  int nfail = 0;
  int nconv = 0;
  int valid_cnt = 0;
  bit ext_on = 0;
  bit nack_sent = 0;
  int exp_list[$];
  int exp_ch[$];
  int exp_q[$];
  int scan_data[$];
  string rd_tag = "R6 read data";

  task automatic chk(bit ok, string tag, int act, int exp);
    ncomp++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model: checks each request against the expected channel queue
  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      while (conv_start) begin
        int ch;
        int e;
        logic [7:0] d;
        ch = int'(conv_ch);
        if (exp_ch.size() == 0) chk(1'b0, "R4 unexpected conversion start", ch, -1);
        else begin
          e = exp_ch.pop_front();
          chk(ch == e, "R2 channel order", ch, e);
        end
        if (ext_on) chk(hold_scl == 1'b0, "R10 no stretch in external mode", hold_scl, 0);
        else        chk(hold_scl == 1'b1, "R5 stretch during conversion", hold_scl, 1);
        nconv++;
        repeat (LAT - 1) @(negedge clk);
        d = {4'(ch), 4'(nconv)};
        conv_done = 1'b1;
        conv_data = d;
        if (ext_on) begin
          if (!nack_sent) exp_q.push_back(int'(d));
        end else scan_data.push_back(int'(d));
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  // monitor: pops the scoreboard as bytes appear
  always @(negedge clk) begin
    if (rd_valid) begin
      int e;
      valid_cnt++;
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected read data", int'(rd_data), -1);
      else begin
        e = exp_q.pop_front();
        chk(int'(rd_data) == e, ext_on ? "R10 streamed data" : rd_tag, int'(rd_data), e);
      end
    end
  end

  task automatic wr(logic [7:0] b);
    @(negedge clk); wr_valid = 1'b1; wr_byte = b;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic set_setup(bit rs, bit ext);
    wr({1'b1, rs, 2'b00, ext, 3'b000});
  endtask

  task automatic set_config(int mode, int sel);
    wr({1'b0, 2'(mode), 1'b0, 3'(sel), 1'b0});
  endtask

  task automatic build(int mode, int sel, bit rs);
    exp_list.delete();
    case (mode)
      0: for (int c = 0; c <= sel; c++) if (!(rs && c == NCH - 1)) exp_list.push_back(c);
      1: for (int k = 0; k < DEPTH; k++) exp_list.push_back(sel);
      2: if (sel < NCH / 2) exp_list.push_back(sel);
         else for (int c = NCH / 2; c <= sel; c++) if (!(rs && c == NCH - 1)) exp_list.push_back(c);
      default: exp_list.push_back(sel);
    endcase
  endtask

  task automatic pulse_addr();
    @(negedge clk); addr_rd = 1'b1;
    @(negedge clk); addr_rd = 1'b0;
  endtask

  task automatic begin_scan(output int n0);
    foreach (exp_list[i]) exp_ch.push_back(exp_list[i]);
    scan_data.delete();
    n0 = nconv;
    pulse_addr();
    chk(hold_scl == 1'b1, "R5 stretch right after address", hold_scl, 1);
  endtask

  task automatic end_scan(int n0);
    for (int i = 0; i < 4000 && hold_scl; i++) @(negedge clk);
    chk(hold_scl == 1'b0, "R5 stretch released", hold_scl, 0);
    chk(nconv - n0 == exp_list.size(), "R4 conversion count", nconv - n0, exp_list.size());
    chk(exp_ch.size() == 0, "R4 all listed channels converted", exp_ch.size(), 0);
    exp_ch.delete();
  endtask

  task automatic run_scan();
    int n0;
    begin_scan(n0);
    end_scan(n0);
  endtask

  task automatic read_n(int n, string tag);
    rd_tag = tag;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(scan_data[i % scan_data.size()]);
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
    end
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R6 every read answered", exp_q.size(), 0);
    rd_tag = "R6 read data";
  endtask

  initial begin
    int vc0;
    int n0;
    rst_n = 1'b0; wr_valid = 1'b0; wr_byte = '0; addr_rd = 1'b0;
    rd_req = 1'b0; rd_nack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hold_scl == 1'b0, "R5 reset no stretch", hold_scl, 0);
    chk(conv_start == 1'b0, "R4 reset no request", conv_start, 0);
    chk(rd_valid == 1'b0, "R7 reset no data", rd_valid, 0);

    // R7: read before any scan
    vc0 = valid_cnt;
    @(negedge clk); rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(valid_cnt == vc0, "R7 read before any scan ignored", valid_cnt - vc0, 0);

    // R1 reset defaults: mode 11, channel 0; R6 single result repeats
    build(3, 0, 0);
    run_scan();
    read_n(3, "R1 default single channel 0 readback");

    // R2 mode 00 up to 5, wrap on reads
    set_config(0, 5);
    build(0, 5, 0);
    run_scan();
    read_n(9, "R6 wrap after last result");

    // R3 reference sharing in mode 00, selected channel is the shared one
    set_setup(1, 0);
    set_config(0, 7);
    build(0, 7, 1);
    run_scan();
    read_n(7, "R3 skip shared channel mode 00");

    // R3 mode 10 with sharing
    set_config(2, 7);
    build(2, 7, 1);
    run_scan();
    read_n(3, "R3 skip shared channel mode 10");

    // R2 mode 10 below the upper half
    set_config(2, 2);
    build(2, 2, 1);
    run_scan();
    read_n(2, "R2 upper mode below half");

    // R2 mode 10 without sharing
    set_setup(0, 0);
    set_config(2, 6);
    build(2, 6, 0);
    run_scan();
    read_n(3, "R2 upper mode range");

    // R3 repeat mode converts the shared channel even with sharing on
    set_setup(1, 0);
    set_config(1, 7);
    build(1, 7, 1);
    run_scan();
    read_n(DEPTH + 1, "R3 repeat mode keeps shared channel");

    // R8 / R7: strobe, config and read during a running scan
    set_setup(0, 0);
    set_config(0, 3);
    build(0, 3, 0);
    begin_scan(n0);
    vc0 = valid_cnt;
    pulse_addr();
    set_config(3, 1);
    @(negedge clk); rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    chk(hold_scl == 1'b1, "R8 scan still running", hold_scl, 1);
    end_scan(n0);
    chk(valid_cnt == vc0, "R7 read during stretch ignored", valid_cnt - vc0, 0);
    read_n(2, "R8 results of the original list");

    // R8 new config used by the next scan; R9 reading restarts at first new result
    build(3, 1, 0);
    run_scan();
    read_n(2, "R9 reads restart on new scan");

    // R10 external-clock streaming until nack
    set_setup(0, 1);
    set_config(0, 2);
    build(0, 2, 0);
    for (int r = 0; r < 3; r++) foreach (exp_list[i]) exp_ch.push_back(exp_list[i]);
    ext_on = 1'b1;
    nack_sent = 1'b0;
    n0 = nconv;
    vc0 = valid_cnt;
    pulse_addr();
    for (int i = 0; i < 4000 && (nconv - n0) < 7; i++) @(negedge clk);
    rd_nack = 1'b1;
    nack_sent = 1'b1;
    @(negedge clk); rd_nack = 1'b0;
    repeat (12) @(negedge clk);
    chk(nconv - n0 == 7, "R10 no conversion after nack", nconv - n0, 7);
    chk(valid_cnt - vc0 == 6, "R10 in-flight result dropped", valid_cnt - vc0, 6);
    chk(exp_q.size() == 0, "R10 all streamed results seen", exp_q.size(), 0);
    chk(hold_scl == 1'b0, "R10 idle after nack", hold_scl, 0);
    ext_on = 1'b0;
    exp_ch.delete();

    // R9 back to internal clock: fresh results only
    set_setup(0, 0);
    set_config(0, 1);
    build(0, 1, 0);
    run_scan();
    read_n(4, "R9 fresh results after streaming");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncomp, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    ncomp++;
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncomp, nfail);
    $finish;
  end

endmodule